// File: doc/BRIEF.md
# Command Completion Counter and Interrupt

This block sits beside one channel of a list-driven DMA engine. It counts the channel's event pulses and turns them into a single interrupt line for software. Two 6-bit counters share one status word. The hardware advances the done counter on every event. Software writes the processed counter back to acknowledge what it has handled, and the number of events still waiting is (done − processed) mod 64. The first event after a list is started means the command list was loaded. Every later event means one command finished. The two kinds are routed to separate interrupt enables.

A small state machine tracks the list. It has three states. LST_IDLE means the list is stopped. LST_WAIT_LOAD means the list is running and its load event has not arrived yet. LST_ACTIVE means the list has been loaded. The transitions are: IDLE→WAIT_LOAD when the control word is written with its run bit set; WAIT_LOAD→ACTIVE on the next event; any state→IDLE when the control word is written with the run bit clear. A separate down-counter gives the remaining byte count of the command in flight. It shows all ones when nothing is left, and command lengths are clamped so that the all-ones value never stands for a full-size command.

Register map, by word address (`reg_addr_i`):
- Address 0, configuration: bit 31 enables interrupts on load events, bit 29 enables interrupts on completion events, bit 28 selects level mode (1) or pulse mode (0).
- Address 1, control: bit 4 is the list run bit.
- Address 2, status: bits 5:0 hold the done count (read only), bit 8 is the interrupt-active flag, bits 21:16 hold the processed count, bit 24 reads 1 in LST_ACTIVE.
- Address 3, remaining: bits 23:0 hold the remaining byte count minus one.

All four addresses read back through `reg_rdata_o`, which follows `reg_addr_i` combinationally.

Top module: `cmd_done_irq`

## Requirements
- R1: After reset the status word reads 0, the remaining word reads 0x00FFFFFF, and `irq_o` is 0.
- R2: Each cycle with `evt_i` high advances the done field (status bits 5:0) by one, modulo 64. No other cycle changes it.
- R3: The first event after the run bit (control bit 4) is written to 1 from the stopped state is a load event. It sets status bit 24 and sets interrupt-active only when config bit 31 is 1. Later events are completion events and set interrupt-active (status bit 8) only when config bit 29 is 1.
- R4: In level mode (config bit 28 = 1), `irq_o` is high exactly while interrupt-active is set, or while done differs from processed and config bit 29 is 1.
- R5: A write to status loads the processed field (status bits 21:16) from write data bits 21:16.
- R6: A status write with data bit 8 = 0 clears interrupt-active. A status write with data bit 8 = 1 leaves it unchanged.
- R7: An event in the same cycle as a status write is still counted, and if its enable is set it leaves interrupt-active set.
- R8: In pulse mode (config bit 28 = 0), `irq_o` is high for exactly one cycle after each event that sets interrupt-active.
- R9: A status write never changes the done field.
- R10: `cmd_load_i` loads the remaining count from `cmd_len_m1_i`. Each `beat_i` lowers it by BUS_BYTES (4). A beat that would take it below zero sets it to all ones, and a beat while it is all ones is ignored. A load in the same cycle as a beat takes priority.
- R11: A loaded length above 2^24 − 1 − BUS_BYTES (0xFFFFFB) is clamped to 0xFFFFFB.
- R12: Writing the run bit to 0 returns the list to the stopped state (status bit 24 reads 0). A later restart makes the next event a load event again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | One-cycle event pulse from the channel engine |
| cmd_load_i | input | 1 | Start of a new command; loads the remaining count |
| cmd_len_m1_i | input | 24 | Command length in bytes, minus one |
| beat_i | input | 1 | One bus beat of the current command moved |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt line (level or one-cycle pulse) |

## Verification
If the done or processed counter is wrong, the error shows in the status word on the cycle after the event. It also changes the level of `irq_o`, because the pending term compares the two counters. A state machine in the wrong state sends an event to the wrong enable, so interrupt-active is set or missing one cycle after that event, and status bit 24 reads the wrong value. A remaining counter that fails to clamp or saturate shows in the remaining word on the cycle after the beat or load. The race between an acknowledgement write and an event is driven in the same cycle, so a lost event appears at once as a stale done field and a low interrupt.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
    typedef enum logic [1:0] {
        LST_IDLE      = 2'd0,
        LST_WAIT_LOAD = 2'd1,
        LST_ACTIVE    = 2'd2
    } lst_state_t;

    localparam logic [1:0] REG_CFG = 2'd0;
    localparam logic [1:0] REG_CTL = 2'd1;
    localparam logic [1:0] REG_STS = 2'd2;
    localparam logic [1:0] REG_REM = 2'd3;

    localparam int CFG_LIST_IEN = 31;
    localparam int CFG_IEN      = 29;
    localparam int CFG_LEVEL    = 28;
    localparam int CTL_RUN      = 4;
    localparam int STS_DONE_LSB = 0;
    localparam int STS_INT      = 8;
    localparam int STS_PROC_LSB = 16;
    localparam int STS_LOADED   = 24;
endpackage

// File: rtl/cdi_list_fsm.sv
module cdi_list_fsm
    import cdi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_wr,
    input  logic       run_val,
    input  logic       evt,
    output lst_state_t state,
    output logic       load_evt,
    output logic       loaded
);
    lst_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (run_wr && !run_val) begin
            nxt = LST_IDLE;
        end else begin
            unique case (state)
                LST_IDLE:      if (run_wr && run_val) nxt = LST_WAIT_LOAD;
                LST_WAIT_LOAD: if (evt) nxt = LST_ACTIVE;
                LST_ACTIVE:    nxt = LST_ACTIVE;
                default:       nxt = LST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_evt = evt && (state == LST_WAIT_LOAD);
        loaded   = (state == LST_ACTIVE);
    end
endmodule

// File: rtl/cdi_evt_count.sv
module cdi_evt_count #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             set_int,
    input  logic             ack_wr,
    input  logic [CNT_W-1:0] ack_cnt,
    input  logic             ack_int,
    output logic [CNT_W-1:0] done_cnt,
    output logic [CNT_W-1:0] proc_cnt,
    output logic             int_active,
    output logic             int_pulse
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_cnt   <= '0;
            proc_cnt   <= '0;
            int_active <= 1'b0;
            int_pulse  <= 1'b0;
        end else begin
            if (evt) done_cnt <= done_cnt + CNT_W'(1);
            if (ack_wr) proc_cnt <= ack_cnt;
            if (set_int) int_active <= 1'b1;
            else if (ack_wr && !ack_int) int_active <= 1'b0;
            int_pulse <= set_int;
        end
    end
endmodule

// File: rtl/cdi_remain.sv
module cdi_remain #(
    parameter int SIZE_W    = 24,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] len_m1,
    input  logic              beat,
    output logic [SIZE_W-1:0] remain
);
    localparam logic [SIZE_W-1:0] ALL_ONES = {SIZE_W{1'b1}};
    localparam logic [SIZE_W-1:0] STEP     = SIZE_W'(BUS_BYTES);
    localparam logic [SIZE_W-1:0] LEN_MAX  = ALL_ONES - STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= ALL_ONES;
        end else if (load) begin
            remain <= (len_m1 > LEN_MAX) ? LEN_MAX : len_m1;
        end else if (beat && remain != ALL_ONES) begin
            if (remain < STEP) remain <= ALL_ONES;
            else               remain <= remain - STEP;
        end
    end
endmodule

// File: rtl/cmd_done_irq.sv
module cmd_done_irq
    import cdi_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int SIZE_W    = 24,
    parameter int BUS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              cmd_load_i,
    input  logic [SIZE_W-1:0] cmd_len_m1_i,
    input  logic              beat_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    logic             wr_cfg, wr_ctl, wr_sts;
    logic             cfg_list_ien, cfg_ien, cfg_level;
    lst_state_t       lst_state;
    logic             load_evt, loaded, set_int;
    logic [CNT_W-1:0] done_cnt, proc_cnt;
    logic             int_active, int_pulse, pending;
    logic [SIZE_W-1:0] remain;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata_i;

    always_comb begin
        wr_cfg = reg_wr_i && (reg_addr_i == REG_CFG);
        wr_ctl = reg_wr_i && (reg_addr_i == REG_CTL);
        wr_sts = reg_wr_i && (reg_addr_i == REG_STS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_list_ien <= 1'b0;
            cfg_ien      <= 1'b0;
            cfg_level    <= 1'b0;
        end else if (wr_cfg) begin
            cfg_list_ien <= reg_wdata_i[CFG_LIST_IEN];
            cfg_ien      <= reg_wdata_i[CFG_IEN];
            cfg_level    <= reg_wdata_i[CFG_LEVEL];
        end
    end

    cdi_list_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_wr   (wr_ctl),
        .run_val  (reg_wdata_i[CTL_RUN]),
        .evt      (evt_i),
        .state    (lst_state),
        .load_evt (load_evt),
        .loaded   (loaded)
    );

    assign set_int = evt_i && (load_evt ? cfg_list_ien : cfg_ien);

    cdi_evt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_i),
        .set_int    (set_int),
        .ack_wr     (wr_sts),
        .ack_cnt    (reg_wdata_i[STS_PROC_LSB +: CNT_W]),
        .ack_int    (reg_wdata_i[STS_INT]),
        .done_cnt   (done_cnt),
        .proc_cnt   (proc_cnt),
        .int_active (int_active),
        .int_pulse  (int_pulse)
    );

    cdi_remain #(.SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)) u_rem (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cmd_load_i),
        .len_m1 (cmd_len_m1_i),
        .beat   (beat_i),
        .remain (remain)
    );

    assign pending = (done_cnt != proc_cnt);

    always_comb begin
        if (cfg_level) irq_o = int_active || (pending && cfg_ien);
        else           irq_o = int_pulse;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            REG_CFG: begin
                reg_rdata_o[CFG_LIST_IEN] = cfg_list_ien;
                reg_rdata_o[CFG_IEN]      = cfg_ien;
                reg_rdata_o[CFG_LEVEL]    = cfg_level;
            end
            REG_CTL: reg_rdata_o[CTL_RUN] = (lst_state != LST_IDLE);
            REG_STS: begin
                reg_rdata_o[STS_DONE_LSB +: CNT_W] = done_cnt;
                reg_rdata_o[STS_INT]               = int_active;
                reg_rdata_o[STS_PROC_LSB +: CNT_W] = proc_cnt;
                reg_rdata_o[STS_LOADED]            = loaded;
            end
            REG_REM: reg_rdata_o[SIZE_W-1:0] = remain;
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/cdi_chk.sv
module cdi_chk #(
    parameter int CNT_W     = 6,
    parameter int SIZE_W    = 24,
    parameter int BUS_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_i,
    input logic              cfg_ien,
    input logic              cfg_level,
    input logic              load_evt,
    input logic              irq_o,
    input logic [CNT_W-1:0]  done_cnt,
    input logic              int_active,
    input logic [SIZE_W-1:0] remain
);
    localparam logic [SIZE_W-1:0] ALL_ONES = {SIZE_W{1'b1}};
    localparam logic [SIZE_W-1:0] LEN_MAX  = ALL_ONES - SIZE_W'(BUS_BYTES);

    AST_DONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> done_cnt == CNT_W'($past(done_cnt) + 1'b1)); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_i |=> $stable(done_cnt)); // R9

    AST_EVT_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !load_evt && cfg_ien) |=> int_active); // R7

    AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level && int_active) |-> irq_o); // R4

    AST_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (remain == ALL_ONES) || (remain <= LEN_MAX)); // R11
endmodule

bind cmd_done_irq cdi_chk #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .BUS_BYTES(BUS_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .cfg_ien    (cfg_ien),
    .cfg_level  (cfg_level),
    .load_evt   (load_evt),
    .irq_o      (irq_o),
    .done_cnt   (done_cnt),
    .int_active (int_active),
    .remain     (remain)
);

// File: tb/sim_cmd_done_irq.sv
`timescale 1ns/1ps
module sim_cmd_done_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_i = 1'b0;
    logic        cmd_load_i = 1'b0;
    logic [23:0] cmd_len_m1_i = '0;
    logic        beat_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_addr_i = 2'd0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cmd_done_irq u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cmd_load_i(cmd_load_i),
        .cmd_len_m1_i(cmd_len_m1_i), .beat_i(beat_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    localparam logic [31:0] C_LIEN = 32'h8000_0000;
    localparam logic [31:0] C_IEN  = 32'h2000_0000;
    localparam logic [31:0] C_LVL  = 32'h1000_0000;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic with_evt);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; evt_i = with_evt;
        @(negedge clk);
        reg_wr_i = 1'b0; evt_i = 1'b0;
    endtask

    task automatic ev(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); evt_i = 1'b1;
        end
        @(negedge clk); evt_i = 1'b0;
    endtask

    function automatic logic [31:0] sts(input int done, input int proc_v, input logic ia, input logic ld);
        logic [31:0] s;
        s = '0;
        s[5:0] = 6'(done);
        s[8] = ia;
        s[21:16] = 6'(proc_v);
        s[24] = ld;
        return s;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd2, d); chk("R1 status", d, 32'h0);
        rd(2'd3, d); chk("R1 remain", d, 32'h00FF_FFFF);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_load_and_ack();
        logic [31:0] d;
        wr(2'd0, C_IEN | C_LVL, 1'b0);
        wr(2'd1, 32'h10, 1'b0);
        rd(2'd2, d); chk("R3 not loaded yet", d, sts(0, 0, 0, 0));
        ev(1);
        rd(2'd2, d); chk("R3 load event no int", d, sts(1, 0, 0, 1));
        chk("R4 pending raises irq", {31'b0, irq_o}, 32'h1);
        ev(1);
        rd(2'd2, d); chk("R3 completion sets int", d, sts(2, 0, 1, 1));
        wr(2'd2, 32'h0002_0000, 1'b0);
        rd(2'd2, d); chk("R5 R6 ack", d, sts(2, 2, 0, 1));
        chk("R4 irq low after ack", {31'b0, irq_o}, 32'h0);
        wr(2'd2, 32'h0002_0100, 1'b0);
        rd(2'd2, d); chk("R6 write one keeps clear", d, sts(2, 2, 0, 1));
        chk("R6 irq stays low", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(2'd2, 32'h0002_0000, 1'b1);
        rd(2'd2, d); chk("R7 event during ack", d, sts(3, 2, 1, 1));
        chk("R7 irq high", {31'b0, irq_o}, 32'h1);
        wr(2'd2, 32'h0003_0000, 1'b0);
        chk("R5 irq low after full ack", {31'b0, irq_o}, 32'h0);
        wr(2'd2, 32'h0003_002A, 1'b0);
        rd(2'd2, d); chk("R9 done not writable", d, sts(3, 3, 0, 1));
    endtask

    task automatic t_wrap_and_enable();
        logic [31:0] d;
        ev(70);
        rd(2'd2, d); chk("R2 wrap mod 64", d, sts(9, 3, 1, 1));
        wr(2'd2, 32'h0009_0000, 1'b0);
        wr(2'd0, C_LVL, 1'b0);
        ev(1);
        rd(2'd2, d); chk("R3 ien off no int", d, sts(10, 9, 0, 1));
        chk("R4 pending masked", {31'b0, irq_o}, 32'h0);
        wr(2'd2, 32'h000A_0000, 1'b0);
    endtask

    task automatic t_pulse();
        logic [31:0] d;
        wr(2'd0, C_IEN, 1'b0);
        @(negedge clk); evt_i = 1'b1;
        @(negedge clk); evt_i = 1'b0;
        chk("R8 pulse high", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'b0, irq_o}, 32'h0);
        rd(2'd2, d); chk("R8 int active kept", d, sts(11, 10, 1, 1));
        wr(2'd2, 32'h000B_0000, 1'b0);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        wr(2'd1, 32'h0, 1'b0);
        rd(2'd2, d); chk("R12 stopped", d, sts(11, 11, 0, 0));
        wr(2'd0, C_LIEN | C_LVL, 1'b0);
        wr(2'd1, 32'h10, 1'b0);
        ev(1);
        rd(2'd2, d); chk("R12 R3 reload sets int via list enable", d, sts(12, 11, 1, 1));
        chk("R4 irq from int active", {31'b0, irq_o}, 32'h1);
    endtask

    task automatic t_remain();
        logic [31:0] d;
        @(negedge clk); cmd_load_i = 1'b1; cmd_len_m1_i = 24'd9;
        @(negedge clk); cmd_load_i = 1'b0;
        rd(2'd3, d); chk("R10 load", d, 32'd9);
        @(negedge clk); beat_i = 1'b1;
        @(negedge clk); rd(2'd3, d); chk("R10 beat1", d, 32'd5);
        @(negedge clk); rd(2'd3, d); chk("R10 beat2", d, 32'd1);
        @(negedge clk); rd(2'd3, d); chk("R10 empty all ones", d, 32'h00FF_FFFF);
        @(negedge clk); beat_i = 1'b0;
        rd(2'd3, d); chk("R10 beat ignored when empty", d, 32'h00FF_FFFF);
        @(negedge clk); cmd_load_i = 1'b1; beat_i = 1'b1; cmd_len_m1_i = 24'd100;
        @(negedge clk); cmd_load_i = 1'b0; beat_i = 1'b0;
        rd(2'd3, d); chk("R10 load beats beat", d, 32'd100);
        @(negedge clk); cmd_load_i = 1'b1; cmd_len_m1_i = 24'hFF_FFFF;
        @(negedge clk); rd(2'd3, d); chk("R11 clamp all ones", d, 32'h00FF_FFFB);
        cmd_len_m1_i = 24'hFF_FFFC;
        @(negedge clk); rd(2'd3, d); chk("R11 clamp just above", d, 32'h00FF_FFFB);
        cmd_len_m1_i = 24'hFF_FFFB;
        @(negedge clk); cmd_load_i = 1'b0;
        rd(2'd3, d); chk("R11 max kept", d, 32'h00FF_FFFB);
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_ack();
        t_race();
        t_wrap_and_enable();
        t_pulse();
        t_restart();
        t_remain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule